// File: doc/BRIEF.md
# Rotating Drum Memory Access Sequencer

This block sits between an execute unit and a word-organised store that behaves like a spinning drum. The store is split into tracks of 32 words. Only the word passing under the heads can be reached in a given cycle. A free-running position counter stands for the rotation: it moves forward one word every clock, whether or not anything is happening. A request carries a 10-bit logical address. The upper half picks the track and the lower half picks the word slot. Bit 9 of the address decides whether the track lies in the fixed low group or in a bank chosen by a 4-bit store-select register.

The execute unit presents a request with a valid/ready handshake. Four kinds of request exist:

- a read;
- a read that takes whatever word is under the heads right now;
- a write that changes only the bits named in a mask;
- a request that reprograms the bank register.

The sequencer charges a fixed penalty whenever the track differs from the track of the previous access. It then waits for the target slot to come round and performs the access in exactly that slot. Completion is signalled by a one-cycle pulse, and read data is valid during that pulse. A simple synchronous word RAM behind the sequencer holds the words.

Top module: `drum_access_seq`

## Requirements
- R1: While reset is applied, `curWord` is 0, `busy` is 0, `reqReady` is 1 and `done` is 0. The bank register resets to 1.
- R2: In every clock cycle after reset, `curWord` advances by one modulo 32, including cycles with no request and cycles spent waiting.
- R3: A logical address with bit 9 set maps to the absolute word {bank[3:0], addr[8:0]}. With bit 9 clear it maps to {4'b0, addr[8:0]}. The RAM is indexed by the low RAM_AW bits of the absolute address (default 10).
- R4: `reqOp` 2'b00 is a read and 2'b10 is a masked write. Both perform their RAM access in the cycle whose `curWord` equals addr[4:0]. Let p be `curWord` in the first cycle after the accepting edge, and let k be the penalty from R6. The access happens in cycle k + ((addr[4:0] − p − k) mod 32), counted from 0.
- R5: `reqOp` 2'b01 is a special read. It ignores addr[4:0] and reads the word at the current position in cycle k, with no rotational wait.
- R6: For `reqOp` 2'b00, 2'b01 and 2'b10, the address's track field addr[9:5] is compared with the track field of the previous such request (0 after reset). If they differ, 6 penalty cycles come first. If they match, none are added.
- R7: A masked write changes exactly the stored bits where `reqMask` is 1 and leaves the other bits of the word as they were.
- R8: `reqOp` 2'b11 loads addr[8:5] into the bank register, completes 32 cycles after acceptance (done in cycle 32), and affects the mapping of every later request.
- R9: A request is accepted only when `reqValid` and `reqReady` are both high. `busy` is high and `reqReady` is low from the cycle after acceptance until completion, and a request presented in that time is ignored.
- R10: Completion is a single-cycle `done` pulse in the cycle after the access (or after the 32nd bank-select cycle). For reads, `rdData` carries the word during that pulse, and a new request can be accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word-cycle clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Sequencer idle and able to take a request |
| reqOp | input | 2 | 00 read, 01 special read, 10 masked write, 11 bank select |
| reqAddr | input | 10 | Logical address: track in 9:5, word slot in 4:0 |
| reqData | input | 32 | Write data |
| reqMask | input | 32 | Bit mask for writes, 1 = change the bit |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 32 | Read result, valid with done |
| curWord | output | 5 | Word slot under the heads in this cycle |

## Verification
Several properties are checked on every cycle:

- an access never fires in a slot other than its target;
- a track change never lets the access through in the next cycle;
- busy is raised only after a valid request and falls only together with a done pulse, and done never lasts two cycles.

Other behaviour can only be shown by the bench's scenarios:

- the exact latency of each access, including wrap-around waits and the penalty;
- the data returned under both bank mappings;
- the bit-selective merge of the masked write;
- the 32-cycle bank switch.

The bench also shows that a request driven while busy leaves the stored word untouched.

// File: rtl/drum_seq_pkg.sv
package drum_seq_pkg;

  typedef enum logic [1:0] {
    OP_READ    = 2'b00,
    OP_SPECIAL = 2'b01,
    OP_WRITE   = 2'b10,
    OP_SELECT  = 2'b11
  } drumOp_e;

  // strobes from the sequencer control to the datapath
  typedef struct packed {
    logic loadReq;    // capture request address, data and mask
    logic loadMl;     // remember the track of this access
    logic loadWs;     // copy bank field into the bank register
    logic ramEn;      // RAM access in this cycle
    logic ramWe;      // the access is a masked write
    logic useCurPos;  // take the word slot from the position counter
  } drumStrobe_t;

endpackage

// File: rtl/drum_seq_ram.sv
module drum_seq_ram #(
  parameter int WORD_W = 32,
  parameter int RAM_AW = 10
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [RAM_AW-1:0] addr,
  input  logic [WORD_W-1:0] wData,
  input  logic [WORD_W-1:0] wMask,
  output logic [WORD_W-1:0] rData
);
  localparam int DEPTH = 1 << RAM_AW;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= (mem[addr] & ~wMask) | (wData & wMask);
      else    rData <= mem[addr];
    end
  end
endmodule

// File: rtl/drum_seq_dp.sv
module drum_seq_dp
  import drum_seq_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int POS_W   = 5,
  parameter int TRACK_W = 5,
  parameter int STORE_W = 4,
  parameter int RAM_AW  = 10
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  drumStrobe_t               strobe,
  input  logic [TRACK_W+POS_W-1:0]  reqAddr,
  input  logic [WORD_W-1:0]         reqData,
  input  logic [WORD_W-1:0]         reqMask,
  output logic                      trackDiff,
  output logic                      wordMatch,
  output logic [POS_W-1:0]          curWord,
  output logic [RAM_AW-1:0]         ramAddr,
  output logic [WORD_W-1:0]         ramWData,
  output logic [WORD_W-1:0]         ramMask
);
  localparam int ADDR_W = TRACK_W + POS_W;
  localparam int ABS_W  = STORE_W + ADDR_W - 1;
  localparam logic [STORE_W-1:0] WS_RESET = STORE_W'(1);

  logic [POS_W-1:0]   curWordQ;
  logic [STORE_W-1:0] wsQ;
  logic [TRACK_W-1:0] mlTrackQ;
  logic [ADDR_W-1:0]  addrQ;
  logic [WORD_W-1:0]  dataQ, maskQ;
  logic [POS_W-1:0]   slot;
  logic [ABS_W-1:0]   absAddr;

  // rotation: one word slot per clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curWordQ <= '0;
    else       curWordQ <= curWordQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wsQ      <= WS_RESET;
      mlTrackQ <= '0;
      addrQ    <= '0;
      dataQ    <= '0;
      maskQ    <= '0;
    end else begin
      if (strobe.loadReq) begin
        addrQ <= reqAddr;
        dataQ <= reqData;
        maskQ <= reqMask;
      end
      if (strobe.loadMl) mlTrackQ <= reqAddr[ADDR_W-1:POS_W];
      if (strobe.loadWs) wsQ <= addrQ[POS_W+STORE_W-1:POS_W];
    end
  end

  assign trackDiff = reqAddr[ADDR_W-1:POS_W] != mlTrackQ;
  assign wordMatch = curWordQ == addrQ[POS_W-1:0];
  assign curWord   = curWordQ;

  // bank mapping: top address bit selects the switchable group
  assign slot    = strobe.useCurPos ? curWordQ : addrQ[POS_W-1:0];
  assign absAddr = addrQ[ADDR_W-1] ? {wsQ, addrQ[ADDR_W-2:POS_W], slot}
                                   : {{STORE_W{1'b0}}, addrQ[ADDR_W-2:POS_W], slot};

  generate
    if (RAM_AW < ABS_W) begin : g_fold
      logic unusedAbsHi;
      assign unusedAbsHi = ^absAddr[ABS_W-1:RAM_AW];
      assign ramAddr = absAddr[RAM_AW-1:0];
    end else begin : g_full
      assign ramAddr = RAM_AW'(absAddr);
    end
  endgenerate

  assign ramWData = dataQ;
  assign ramMask  = maskQ;

  AST_ACCESS_ON_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ramEn && !strobe.useCurPos) |-> (curWordQ == addrQ[POS_W-1:0])); // R4
endmodule

// File: rtl/drum_seq_ctrl.sv
module drum_seq_ctrl
  import drum_seq_pkg::*;
#(
  parameter int SWITCH_PEN    = 6,
  parameter int SELECT_CYCLES = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [1:0]  reqOp,
  input  logic        trackDiff,
  input  logic        wordMatch,
  output logic        reqReady,
  output logic        busy,
  output logic        done,
  output drumStrobe_t strobe
);
  localparam int CNT_MAX = (SWITCH_PEN > SELECT_CYCLES) ? SWITCH_PEN : SELECT_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SWITCH, ST_WAIT, ST_STORE} seqState_e;

  seqState_e  stateQ;
  drumOp_e    opQ, opIn;
  logic [CNT_W-1:0] cntQ;
  logic       doneQ, accept, hit;

  assign opIn     = drumOp_e'(reqOp);
  assign accept   = reqValid && (stateQ == ST_IDLE);
  assign hit      = (opQ == OP_SPECIAL) || wordMatch;
  assign reqReady = stateQ == ST_IDLE;
  assign busy     = stateQ != ST_IDLE;
  assign done     = doneQ;

  always_comb begin
    strobe           = '0;
    strobe.loadReq   = accept;
    strobe.loadMl    = accept && (opIn != OP_SELECT);
    strobe.loadWs    = (stateQ == ST_STORE) && (cntQ == '0);
    strobe.ramEn     = (stateQ == ST_WAIT) && hit;
    strobe.ramWe     = strobe.ramEn && (opQ == OP_WRITE);
    strobe.useCurPos = opQ == OP_SPECIAL;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      opQ    <= OP_READ;
      cntQ   <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= strobe.ramEn || strobe.loadWs;
      unique case (stateQ)
        ST_IDLE: if (accept) begin
          opQ <= opIn;
          if (opIn == OP_SELECT) begin
            stateQ <= ST_STORE;
            cntQ   <= CNT_W'(SELECT_CYCLES - 1);
          end else if (trackDiff && (SWITCH_PEN > 0)) begin
            stateQ <= ST_SWITCH;
            cntQ   <= CNT_W'(SWITCH_PEN - 1);
          end else begin
            stateQ <= ST_WAIT;
          end
        end
        ST_SWITCH: begin
          if (cntQ == '0) stateQ <= ST_WAIT;
          else            cntQ <= cntQ - 1'b1;
        end
        ST_WAIT: if (hit) stateQ <= ST_IDLE;
        ST_STORE: begin
          if (cntQ == '0) stateQ <= ST_IDLE;
          else            cntQ <= cntQ - 1'b1;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  AST_ACCEPT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqValid)); // R9
  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10
  AST_SWITCH_NO_EARLY_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadMl && trackDiff) |=> (busy && !strobe.ramEn)); // R6
endmodule

// File: rtl/drum_access_seq.sv
module drum_access_seq
  import drum_seq_pkg::*;
#(
  parameter int WORD_W        = 32,
  parameter int POS_W         = 5,
  parameter int TRACK_W       = 5,
  parameter int STORE_W       = 4,
  parameter int RAM_AW        = 10,
  parameter int SWITCH_PEN    = 6,
  parameter int SELECT_CYCLES = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  output logic                     reqReady,
  input  logic [1:0]               reqOp,
  input  logic [TRACK_W+POS_W-1:0] reqAddr,
  input  logic [WORD_W-1:0]        reqData,
  input  logic [WORD_W-1:0]        reqMask,
  output logic                     busy,
  output logic                     done,
  output logic [WORD_W-1:0]        rdData,
  output logic [POS_W-1:0]         curWord
);
  drumStrobe_t       strobe;
  logic              trackDiff, wordMatch;
  logic [RAM_AW-1:0] ramAddr;
  logic [WORD_W-1:0] ramWData, ramMask;

  drum_seq_ctrl #(
    .SWITCH_PEN(SWITCH_PEN), .SELECT_CYCLES(SELECT_CYCLES)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .trackDiff(trackDiff), .wordMatch(wordMatch),
    .reqReady(reqReady), .busy(busy), .done(done), .strobe(strobe)
  );

  drum_seq_dp #(
    .WORD_W(WORD_W), .POS_W(POS_W), .TRACK_W(TRACK_W),
    .STORE_W(STORE_W), .RAM_AW(RAM_AW)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .reqData(reqData), .reqMask(reqMask), .trackDiff(trackDiff),
    .wordMatch(wordMatch), .curWord(curWord), .ramAddr(ramAddr),
    .ramWData(ramWData), .ramMask(ramMask)
  );

  drum_seq_ram #(.WORD_W(WORD_W), .RAM_AW(RAM_AW)) ram_i (
    .clk(clk), .en(strobe.ramEn), .we(strobe.ramWe), .addr(ramAddr),
    .wData(ramWData), .wMask(ramMask), .rData(rdData)
  );
endmodule

// File: tb/drum_access_seq_tb_top.sv
module drum_access_seq_tb_top;
  import drum_seq_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqOp = 2'b00;
  logic [9:0]  reqAddr = '0;
  logic [31:0] reqData = '0;
  logic [31:0] reqMask = '0;
  logic        busy, done;
  logic [31:0] rdData;
  logic [4:0]  curWord;

  always #2.5 clk = ~clk;

  drum_access_seq dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqData(reqData), .reqMask(reqMask),
    .busy(busy), .done(done), .rdData(rdData), .curWord(curWord)
  );

  typedef struct {
    int          doneEdge;
    bit          chkData;
    logic [31:0] data;
    string       tag;
  } expItem_t;

  expItem_t    expQ[$];
  logic [31:0] memModel [int];
  int          wsModel = 1;
  int          mlTrackModel = 0;
  int          edgeCnt = 0;
  int          mw = 0;
  int          checks = 0;
  int          fails = 0;
  bit          prevDone = 0;

  // model of rotation and edge count
  always @(posedge clk) begin
    edgeCnt++;
    if (!rstN) mw = 0;
    else       mw = (mw + 1) % 32;
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int ramIdx(logic [9:0] a, int pos);
    int absA;
    if (a[9]) absA = (wsModel << 9) | (int'(a[8:5]) << 5) | pos;
    else      absA = (int'(a[8:5]) << 5) | pos;
    return absA & 1023;
  endfunction

  task automatic issue(logic [1:0] op, logic [9:0] a, logic [31:0] d, logic [31:0] m, string tag);
    int e0, p, pen, acc, idx;
    expItem_t it;
    while (!reqReady) @(negedge clk);
    check(curWord == 5'(mw), "R2", "curWord before request", curWord, mw);
    reqValid = 1'b1; reqOp = op; reqAddr = a; reqData = d; reqMask = m;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    e0 = edgeCnt;
    p  = mw;
    check(busy && !reqReady, "R9", "busy/ready after accept", {busy, reqReady}, 2'b10);
    it.tag = tag;
    it.chkData = 0;
    it.data = '0;
    if (op == OP_SELECT) begin
      wsModel = int'(a[8:5]);
      it.doneEdge = e0 + 32;
    end else begin
      pen = (int'(a[9:5]) != mlTrackModel) ? 6 : 0;
      mlTrackModel = int'(a[9:5]);
      if (op == OP_SPECIAL) acc = pen;
      else acc = pen + ((int'(a[4:0]) - p - pen) % 32 + 32) % 32;
      idx = ramIdx(a, (op == OP_SPECIAL) ? (p + acc) % 32 : int'(a[4:0]));
      it.doneEdge = e0 + acc + 1;
      if (op == OP_WRITE) begin
        if (memModel.exists(idx)) memModel[idx] = (memModel[idx] & ~m) | (d & m);
        else                      memModel[idx] = d & m;
      end else begin
        it.chkData = 1;
        it.data = memModel.exists(idx) ? memModel[idx] : 32'hx;
      end
    end
    expQ.push_back(it);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (prevDone) check(!done, "R10", "done is a single pulse", done, 0);
      prevDone = done;
      if (done) begin
        if (expQ.size() == 0) begin
          check(0, "R9", "unexpected completion", 1, 0);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check(edgeCnt == it.doneEdge, "R4/R6", {it.tag, " latency"}, edgeCnt, it.doneEdge);
          if (it.chkData)
            check(rdData === it.data, "R10", {it.tag, " data"}, rdData, it.data);
        end
      end
    end
  end

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "WDOG", "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    check(curWord == 0, "R1", "reset curWord", curWord, 0);
    check(!busy && reqReady && !done, "R1", "reset busy/ready/done",
          {busy, reqReady, done}, 3'b010);
    rstN = 1'b1;

    // R1 R3: bank 1 at reset keeps 0x205 apart from 0x005
    issue(OP_WRITE, 10'h205, 32'hB0B0_1111, '1, "R1 R3 bank write");
    issue(OP_WRITE, 10'h005, 32'h0000_5555, '1, "R3 perm write");
    issue(OP_READ,  10'h205, '0, '0, "R1 R3 bank read");
    issue(OP_READ,  10'h005, '0, '0, "R3 perm read");

    // R4: fill a whole track, each write waits for its slot
    for (int i = 0; i < 32; i++)
      issue(OP_WRITE, 10'(10'h040 + i), 32'hA500_0000 + 32'(i * 32'h111), '1, "R4 track fill");

    // R4 R6: same-track reads with wrap, then a track change
    issue(OP_READ, 10'h047, '0, '0, "R4 same track");
    issue(OP_READ, 10'h043, '0, '0, "R6 same track wrap");
    issue(OP_READ, 10'h01F, '0, '0, "R6 track change");

    // R7: masked write merges only the selected bits
    issue(OP_WRITE, 10'h005, 32'h1234_5678, 32'h0000_FFFF, "R7 masked write");
    issue(OP_READ,  10'h005, '0, '0, "R7 merged read");
    issue(OP_WRITE, 10'h005, 32'hFF00_0000, 32'hF000_000F, "R7 second mask");
    issue(OP_READ,  10'h005, '0, '0, "R7 merged read 2");

    // R5: special reads, with and without a track change
    issue(OP_SPECIAL, 10'h040, '0, '0, "R5 R6 special after change");
    issue(OP_SPECIAL, 10'h05F, '0, '0, "R5 special same track");
    repeat (3) @(negedge clk);
    issue(OP_SPECIAL, 10'h051, '0, '0, "R5 special later slot");

    // R8 R9: bank select to 2, request driven while busy is ignored
    issue(OP_SELECT, 10'h040, '0, '0, "R8 select bank");
    reqValid = 1'b1; reqOp = OP_WRITE; reqAddr = 10'h005;
    reqData = 32'hDEAD_BEEF; reqMask = '1;
    repeat (4) @(negedge clk);
    reqValid = 1'b0;

    // R8 R3: bank 2 maps 0x205 onto the permanent word 0x005
    issue(OP_READ, 10'h205, '0, '0, "R8 read through new bank");
    issue(OP_READ, 10'h005, '0, '0, "R9 word unchanged by ignored request");
    issue(OP_WRITE, 10'h3E1, 32'hCAFE_0042, '1, "R3 bank write high track");
    issue(OP_READ,  10'h3E1, '0, '0, "R3 bank read high track");
    issue(OP_READ,  10'h205, '0, '0, "R6 return track");

    while (expQ.size() != 0 || busy) @(negedge clk);
    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule